// File: doc/BRIEF.md
# Rotating Word Seven-Segment Display

This block drives a row of eight seven-segment digits with a word of up to five characters. Five 3-bit character codes arrive side by side on one input bus. The word is padded on the right with three blank positions to fill the eight digits. A 3-bit rotation amount then turns this padded sequence circularly, so characters that leave the left end come back in at the right end.

Each digit position has its own selection network. The network picks one of the five character codes, or a forced blank, from the rotation amount. A per-digit decoder then turns the chosen code into an active-low segment pattern. The block has no clock and no storage, so its outputs follow its inputs directly. It has no streaming data, so there is no valid/ready interface and no back-pressure. Both inputs are plain level controls.

Top module: `rwd_rotator`

## Requirements
- R1: The character codes are H=000, E=001, L=010 and O=011. A lit segment is driven to 0 and a dark segment to 1.
- R2: Codes 100, 101, 110 and 111 all give a fully dark digit, with all seven segment bits at 1.
- R3: Segment index 0 is the top bar. Indices 1 to 5 go clockwise round the outer bars: upper right, lower right, bottom, lower left, upper left. Index 6 is the middle bar. Within each digit's 7-bit group, index 0 is the most significant bit. The resulting patterns are H=1001000, E=0110000, L=1110001 and O=0000001.
- R4: With rotation 0, character 0 appears on digit 7 (leftmost) and character k appears on digit 7-k. Digits 2, 1 and 0 are blank.
- R5: Each increment of the rotation moves every character one digit to the left, and digit 7 wraps to digit 0. Digit d shows padded position (7-d+rot) mod 8, where positions 0 to 4 are characters 0 to 4 and positions 5 to 7 are blanks.
- R6: The three padding blanks rotate together with the characters. The number of dark digits is always 3 plus the number of blank codes in the word.
- R7: Character k is carried on bits [3k+2:3k] of the word bus.
- R8: The outputs are combinational. A change of either input shows on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rot_sel | input | 3 | Rotation amount, 0 to 7 |
| word_codes | input | 15 | Five 3-bit character codes; character k is in bits [3k+2:3k] |
| digit_seg | output | 8x7 | Active-low segment buses, one per digit; element d is digit d, bits ordered 0 to 6 |

## Verification
The hardest case to reach is a blank code inside the word that sits next to the padding blanks while the rotation carries that group across the digit 7 to digit 0 boundary. In that case a fault in blank handling and a fault in wrap handling look alike. The stimulus covers it by sweeping all eight rotations with words that have blank codes at the edges and in the middle, using a different blank code value each time. Every digit is compared against a model of the rotation built inside the bench.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  localparam int CODE_W = 3;
  localparam int SEG_W  = 7;

  typedef enum logic [CODE_W-1:0] {
    GLYPH_H = 3'b000,
    GLYPH_E = 3'b001,
    GLYPH_L = 3'b010,
    GLYPH_O = 3'b011,
    GLYPH_BLANK = 3'b111
  } glyph_e;

  // segment bit order [0:6]: top, up-right, low-right, bottom, low-left, up-left, middle
  typedef logic [0:SEG_W-1] seg_t;
  localparam seg_t SEG_DARK = 7'b1111111;
endpackage

// File: rtl/rwd_slot_select.sv
module rwd_slot_select
  import rwd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int WORD_LEN   = 5,
  parameter int DIGIT      = 0,
  localparam int SEL_W     = $clog2(NUM_DIGITS),
  localparam int BUS_W     = WORD_LEN * CODE_W
) (
  input  logic [SEL_W-1:0]  rot_sel,
  input  logic [BUS_W-1:0]  word_codes,
  output logic [CODE_W-1:0] pick_code
);
  localparam int HOME = NUM_DIGITS - 1 - DIGIT;

  int pos;

  always_comb begin
    pos = (HOME + int'(rot_sel)) % NUM_DIGITS;
    pick_code = GLYPH_BLANK;
    for (int k = 0; k < WORD_LEN; k++) begin
      if (pos == k) pick_code = word_codes[k*CODE_W +: CODE_W];
    end
  end

  always_comb begin
    if (pos >= WORD_LEN)
      AST_PAD_IS_DARK: assert (pick_code[CODE_W-1] == 1'b1); // R6
  end
endmodule

// File: rtl/rwd_glyph_decode.sv
module rwd_glyph_decode
  import rwd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output seg_t              seg_n
);
  always_comb begin
    unique case (code)
      GLYPH_H: seg_n = 7'b1001000;
      GLYPH_E: seg_n = 7'b0110000;
      GLYPH_L: seg_n = 7'b1110001;
      GLYPH_O: seg_n = 7'b0000001;
      default: seg_n = SEG_DARK;
    endcase
  end

  always_comb begin
    if (code[CODE_W-1])
      AST_HIGH_CODES_DARK: assert ($countones(seg_n) == SEG_W); // R2
    if (code == GLYPH_O)
      AST_O_MIDDLE_DARK: assert (seg_n[6] == 1'b1 && $countones(seg_n) == 1); // R3
    if (code == GLYPH_L)
      AST_L_THREE_LIT: assert ($countones(~seg_n) == 3); // R1
  end
endmodule

// File: rtl/rwd_rotator.sv
module rwd_rotator
  import rwd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int WORD_LEN   = 5,
  localparam int SEL_W     = $clog2(NUM_DIGITS),
  localparam int BUS_W     = WORD_LEN * CODE_W
) (
  input  logic [SEL_W-1:0]                   rot_sel,
  input  logic [BUS_W-1:0]                   word_codes,
  output logic [NUM_DIGITS-1:0][0:SEG_W-1]   digit_seg
);
  logic [NUM_DIGITS-1:0][CODE_W-1:0] pick;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    rwd_slot_select #(
      .NUM_DIGITS(NUM_DIGITS),
      .WORD_LEN  (WORD_LEN),
      .DIGIT     (d)
    ) u_sel (
      .rot_sel   (rot_sel),
      .word_codes(word_codes),
      .pick_code (pick[d])
    );

    rwd_glyph_decode u_dec (
      .code (pick[d]),
      .seg_n(digit_seg[d])
    );
  end

  int dark_digits;
  int dark_codes;

  always_comb begin
    dark_digits = 0;
    dark_codes  = 0;
    for (int d = 0; d < NUM_DIGITS; d++)
      if (digit_seg[d] == SEG_DARK) dark_digits++;
    for (int k = 0; k < WORD_LEN; k++)
      if (word_codes[k*CODE_W + CODE_W - 1]) dark_codes++;
    AST_BLANK_BALANCE: assert (dark_digits == dark_codes + NUM_DIGITS - WORD_LEN); // R6
    if (rot_sel == '0)
      AST_HOME_ORDER: assert (pick[NUM_DIGITS-1] == word_codes[CODE_W-1:0]); // R4
  end
endmodule

// File: tb/sim_rwd_rotator.sv
`timescale 1ns/1ps
module sim_rwd_rotator;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]       rot_sel;
  logic [14:0]      word_codes;
  logic [7:0][0:6]  digit_seg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rwd_rotator u0 (
    .rot_sel   (rot_sel),
    .word_codes(word_codes),
    .digit_seg (digit_seg)
  );

  function automatic logic [0:6] ref_glyph(input logic [2:0] c);
    case (c)
      3'd0: return 7'b1001000;
      3'd1: return 7'b0110000;
      3'd2: return 7'b1110001;
      3'd3: return 7'b0000001;
      default: return 7'b1111111;
    endcase
  endfunction

  function automatic logic [2:0] ref_code(input logic [14:0] w, input int r, input int d);
    int p;
    p = (7 - d + r) % 8;
    if (p < 5) return w[p*3 +: 3];
    return 3'b111;
  endfunction

  task automatic chk(input string req, input int d, input logic [0:6] exp);
    checks++;
    if (digit_seg[d] !== exp) begin
      errors++;
      $display("FAIL %s digit %0d rot %0d actual %b expected %b", req, d, rot_sel, digit_seg[d], exp);
    end
  endtask

  task automatic apply(input logic [2:0] r, input logic [14:0] w);
    @(posedge clk);
    rot_sel = r;
    word_codes = w;
    @(negedge clk);
  endtask

  task automatic sweep(input string req, input logic [14:0] w);
    for (int r = 0; r < 8; r++) begin
      apply(3'(r), w);
      for (int d = 0; d < 8; d++) chk(req, d, ref_glyph(ref_code(w, r, d)));
    end
  endtask

  function automatic logic [14:0] mk(input logic [2:0] c0, c1, c2, c3, c4);
    return {c4, c3, c2, c1, c0};
  endfunction

  task automatic t_home;
    // R1 R3 R4 R7: HELLO at rotation 0
    apply(3'd0, mk(3'd0, 3'd1, 3'd2, 3'd2, 3'd3));
    chk("R4", 7, 7'b1001000);
    chk("R3", 6, 7'b0110000);
    chk("R1", 5, 7'b1110001);
    chk("R7", 4, 7'b1110001);
    chk("R3", 3, 7'b0000001);
    for (int d = 0; d < 3; d++) chk("R4", d, 7'b1111111);
  endtask

  task automatic t_wrap;
    // R5: rotation 1 puts character 0 on digit 0
    apply(3'd1, mk(3'd0, 3'd1, 3'd2, 3'd2, 3'd3));
    chk("R5", 0, 7'b1001000);
    chk("R5", 7, 7'b0110000);
    chk("R5", 1, 7'b1111111);
    // R5: rotation 4 puts the O on digit 7
    apply(3'd4, mk(3'd0, 3'd1, 3'd2, 3'd2, 3'd3));
    chk("R5", 7, 7'b0000001);
    chk("R5", 3, 7'b1001000);
  endtask

  task automatic t_high_codes;
    // R2: each of 100..111 in the character 0 slot gives a dark digit 7
    for (int c = 4; c < 8; c++) begin
      apply(3'd0, mk(3'(c), 3'd0, 3'd0, 3'd0, 3'd0));
      chk("R2", 7, 7'b1111111);
      chk("R2", 6, 7'b1001000);
    end
  endtask

  task automatic t_live;
    // R8: no clock edge between input change and sample
    @(negedge clk);
    rot_sel = 3'd2;
    word_codes = mk(3'd3, 3'd3, 3'd3, 3'd3, 3'd3);
    #1;
    chk("R8", 1, 7'b0000001);
    chk("R8", 4, 7'b1111111);
  endtask

  initial begin
    rot_sel = 3'd0;
    word_codes = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: all-H word at rotation 0 after start
    chk("R1", 7, 7'b1001000);
    chk("R4", 0, 7'b1111111);
    t_home();
    t_wrap();
    t_high_codes();
    t_live();
    sweep("R5", mk(3'd0, 3'd1, 3'd2, 3'd2, 3'd3));
    sweep("R6", mk(3'd1, 3'd4, 3'd3, 3'd2, 3'd7));
    sweep("R6", mk(3'd5, 3'd2, 3'd0, 3'd6, 3'd1));
    sweep("R2", mk(3'd3, 3'd0, 3'd2, 3'd1, 3'd6));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R8 actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule